// File: doc/BRIEF.md
# Asynchronous Static Memory Controller

This block sits between a simple on-chip request/acknowledge port and external asynchronous parts such as SRAM, ROM, NOR Flash and peripherals with an SRAM-like interface. The top address bits of a request select one of several regions, and each region owns a chip-select line. Every region has its own setup, access and hold counts. The controller plays each request out on the pins as one or more timed device cycles, then returns a one-cycle acknowledge. Read data comes back with that acknowledge.

Each region also chooses three things: the device width (8 or 16 bits), how the two byte lanes of a 16-bit part are qualified, and whether an external ready line may stretch the access phase. If the ready line is used, the region also picks its polarity. Host byte, half-word and word accesses work the same way on either device width. The controller splits a wide access into as many device cycles as the part needs. Configuration is held steady on input ports. The data pins are presented as separate out, enable and in signals, which the pad ring joins into one bidirectional bus.

Top module: `asmc_top`

## Requirements
- R1: While no device cycle is in progress, all chip selects and strobes are high, `memAddr`, `memA0` and `memDataOut` are zero, and `memDataOe` is 1.
- R2: Region index = `reqAddr[ADDR_W-1 -: SEL_W]`. An index below NUM_CS asserts (low) only `memCsN[index]`. An index of NUM_CS or more asserts no chip select: `reqAck` is given in the cycle after acceptance, with `rspRdata` = 0.
- R3: Each device cycle spans setup+1, then at least access+1, then hold+1 clock cycles, counted in the region's fields. Chip select stays low across the whole span and across consecutive device cycles of one request. `memOeN` (read) and the write strobes go low only in the access phase.
- R4: When the region's ready-enable bit is 0, `readyIn` has no effect: the access phase lasts exactly access+1 cycles.
- R5: When ready-enable is 1, the access phase goes on past access+1 cycles until ready is seen at a clock edge. Ready is `readyIn`=1 when the polarity bit is 0, and `readyIn`=0 when the polarity bit is 1.
- R6: 8-bit region (`cfgWide`=0): `memAddr` = byte offset bits [OFF_W-1:1] and `memA0` = offset bit 0. Data uses `memDataOut[7:0]`, with bits [15:8] driven 0. `memWeN` is the only write strobe. `memStrbHiN` and `memStrbLoN` stay high.
- R7: 16-bit region with `cfgByteEn`=0: `memStrbHiN` is the write strobe for the odd byte (bits 15:8) and `memStrbLoN` for the even byte (bits 7:0). Only written lanes pulse. `memWeN` stays high and `memA0` is 0.
- R8: 16-bit region with `cfgByteEn`=1: `memWeN` is the write strobe. `memStrbHiN` and `memStrbLoN` are byte enables, held low for the whole span on the lanes touched, for reads and writes.
- R9: `reqSize` encodes 00=byte, 01=half-word, 10 or 11=word. Address bits below the access size are ignored. A word takes two device cycles on a 16-bit part (lower half first) and four on an 8-bit part (ascending bytes). A half-word takes two cycles on an 8-bit part.
- R10: The host byte at offset k within a word travels in `reqWdata`/`rspRdata` bits [8k+7:8k]. On a 16-bit part the bus carries the half-word that contains the current address. Read bytes are gathered into their host lanes, and lanes that were not read return 0.
- R11: `reqAck` is a one-cycle pulse in the cycle after the last hold cycle. A new request is accepted from the idle cycle that follows.
- R12: During a read span `memDataOe` is 0. During a write span `memDataOe` is 1 and `memDataOut` holds the current device cycle's write data from first setup to last hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present; held until acknowledged |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 2 | Access size code |
| reqAddr | input | ADDR_W | Byte address, region index in top bits |
| reqWdata | input | 32 | Host write data |
| reqAck | output | 1 | One-cycle completion pulse |
| rspRdata | output | 32 | Assembled read data, valid with acknowledge |
| cfgSetup | input | NUM_CS*CNT_W | Per-region setup count |
| cfgAccess | input | NUM_CS*CNT_W | Per-region access count |
| cfgHold | input | NUM_CS*CNT_W | Per-region hold count |
| cfgReadyEn | input | NUM_CS | Per-region ready enable |
| cfgReadyPol | input | NUM_CS | Per-region ready polarity, 1 = active low |
| cfgWide | input | NUM_CS | Per-region device width, 1 = 16-bit |
| cfgByteEn | input | NUM_CS | Per-region byte-enable style for 16-bit parts |
| readyIn | input | 1 | External ready/wait line |
| memCsN | output | NUM_CS | Active-low chip selects |
| memAddr | output | ADDR_W-SEL_W-1 | Device address, offset bits [OFF_W-1:1] |
| memA0 | output | 1 | Byte address bit 0 for 8-bit parts |
| memDataOut | output | 16 | Data driven toward the device |
| memDataOe | output | 1 | Data output enable |
| memDataIn | input | 16 | Data from the device |
| memOeN | output | 1 | Active-low read strobe |
| memWeN | output | 1 | Active-low single write strobe |
| memStrbHiN | output | 1 | Upper write strobe or upper byte enable |
| memStrbLoN | output | 1 | Lower write strobe or lower byte enable |

## Verification
The end of a read access phase and the ready decision fall on the same clock edge. Data is captured only at the edge where the counted cycles are used up and ready is seen together. The bench gives ready at that exact last counted cycle on one region, and several cycles late on another. It then judges both the strobe length, cycle by cycle, and the read data returned with the acknowledge. A second collision is the end of one hold phase with the start of the next device cycle's setup. This is driven with word accesses on both device widths, and the bench checks that the chip select stays low while the address and write data step to the next device cycle in that same cycle.

// File: rtl/asmc_pkg.sv
package asmc_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE     = 2'b00,
    SZ_HALF     = 2'b01,
    SZ_WORD     = 2'b10,
    SZ_WORD_ALT = 2'b11
  } hostSize_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_ACCESS,
    PH_HOLD,
    PH_ACK
  } phase_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic      load;     // accept a new request this cycle
    logic      span;     // a device cycle is on the pins
    logic      access;   // access phase
    logic      capture;  // last access edge of a read
    logic      advance;  // step to the next device cycle
    logic      isWrite;
    logic      wide;     // 16-bit part
    logic      beStyle;  // byte-enable pin style
    hostSize_e size;
  } ctlStrobes_t;

  function automatic logic [1:0] lastBeatFor(hostSize_e sz, logic wide);
    case (sz)
      SZ_BYTE: lastBeatFor = 2'd0;
      SZ_HALF: lastBeatFor = wide ? 2'd0 : 2'd1;
      default: lastBeatFor = wide ? 2'd1 : 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/asmc_ctrl.sv
module asmc_ctrl
  import asmc_pkg::*;
#(
  parameter int NUM_CS = 10,
  parameter int CNT_W  = 4,
  localparam int SEL_W = $clog2(NUM_CS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic                    reqWrite,
  input  hostSize_e               reqSize,
  input  logic [SEL_W-1:0]        reqRegion,
  input  logic [NUM_CS*CNT_W-1:0] cfgSetup,
  input  logic [NUM_CS*CNT_W-1:0] cfgAccess,
  input  logic [NUM_CS*CNT_W-1:0] cfgHold,
  input  logic [NUM_CS-1:0]       cfgReadyEn,
  input  logic [NUM_CS-1:0]       cfgReadyPol,
  input  logic [NUM_CS-1:0]       cfgWide,
  input  logic [NUM_CS-1:0]       cfgByteEn,
  input  logic                    readyIn,
  output logic                    reqAck,
  output logic [NUM_CS-1:0]       memCsN,
  output ctlStrobes_t             ctl
);

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       beatQ;
  logic [1:0]       lastBeatQ;
  logic [SEL_W-1:0] regQ;
  logic             writeQ;
  hostSize_e        sizeQ;

  logic             reqInRange;
  logic [SEL_W-1:0] reqSafe;
  logic [CNT_W-1:0] setupReq, setupCur, accessCur, holdCur;
  logic             readyOk;
  logic             lastCount;

  assign reqInRange = (int'(reqRegion) < NUM_CS);
  assign reqSafe    = reqInRange ? reqRegion : '0;

  assign setupReq  = cfgSetup [reqSafe*CNT_W +: CNT_W];
  assign setupCur  = cfgSetup [regQ*CNT_W +: CNT_W];
  assign accessCur = cfgAccess[regQ*CNT_W +: CNT_W];
  assign holdCur   = cfgHold  [regQ*CNT_W +: CNT_W];

  assign readyOk   = !cfgReadyEn[regQ] || (readyIn ^ cfgReadyPol[regQ]);
  assign lastCount = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      beatQ     <= '0;
      lastBeatQ <= '0;
      regQ      <= '0;
      writeQ    <= 1'b0;
      sizeQ     <= SZ_BYTE;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (reqValid) begin
            writeQ <= reqWrite;
            sizeQ  <= reqSize;
            regQ   <= reqSafe;
            beatQ  <= '0;
            if (reqInRange) begin
              phase     <= PH_SETUP;
              cnt       <= setupReq;
              lastBeatQ <= lastBeatFor(reqSize, cfgWide[reqSafe]);
            end else begin
              phase <= PH_ACK;
            end
          end
        end
        PH_SETUP: begin
          if (lastCount) begin
            phase <= PH_ACCESS;
            cnt   <= accessCur;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_ACCESS: begin
          if (!lastCount) begin
            cnt <= cnt - 1'b1;
          end else if (readyOk) begin
            phase <= PH_HOLD;
            cnt   <= holdCur;
          end
        end
        PH_HOLD: begin
          if (!lastCount) begin
            cnt <= cnt - 1'b1;
          end else if (beatQ == lastBeatQ) begin
            phase <= PH_ACK;
          end else begin
            beatQ <= beatQ + 2'd1;
            phase <= PH_SETUP;
            cnt   <= setupCur;
          end
        end
        PH_ACK:  phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.load    = (phase == PH_IDLE) && reqValid;
    ctl.span    = (phase == PH_SETUP) || (phase == PH_ACCESS) || (phase == PH_HOLD);
    ctl.access  = (phase == PH_ACCESS);
    ctl.capture = (phase == PH_ACCESS) && lastCount && readyOk && !writeQ;
    ctl.advance = (phase == PH_HOLD) && lastCount && (beatQ != lastBeatQ);
    ctl.isWrite = writeQ;
    ctl.wide    = cfgWide[regQ];
    ctl.beStyle = cfgByteEn[regQ];
    ctl.size    = sizeQ;
  end

  assign reqAck = (phase == PH_ACK);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign memCsN[g] = !(ctl.span && (int'(regQ) == g));
  end

endmodule

// File: rtl/asmc_datapath.sv
module asmc_datapath
  import asmc_pkg::*;
#(
  parameter int OFF_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  hostSize_e         reqSize,
  input  logic [OFF_W-1:0]  reqOffset,
  input  logic [31:0]       reqWdata,
  input  logic [15:0]       memDataIn,
  output logic [31:0]       rspRdata,
  output logic [OFF_W-2:0]  memAddr,
  output logic              memA0,
  output logic [15:0]       memDataOut,
  output logic              memDataOe,
  output logic              memOeN,
  output logic              memWeN,
  output logic              memStrbHiN,
  output logic              memStrbLoN
);

  logic [OFF_W-1:0] curQ;
  logic [31:0]      wdataQ;
  logic [31:0]      rdataQ;
  logic [OFF_W-1:0] alignedOff;
  logic [1:0]       lane;
  logic [15:0]      beatHalf;
  logic [7:0]       beatByte;
  logic             byteOnly;
  logic             hiLane;
  logic             loLane;
  logic             writePulse;

  always_comb begin
    alignedOff = reqOffset;
    if (reqSize == SZ_HALF)      alignedOff[0]   = 1'b0;
    else if (reqSize != SZ_BYTE) alignedOff[1:0] = 2'b00;
  end

  assign lane     = curQ[1:0];
  assign beatHalf = wdataQ[{lane[1], 4'b0000} +: 16];
  assign beatByte = wdataQ[{lane, 3'b000} +: 8];
  assign byteOnly = (ctl.size == SZ_BYTE);
  assign hiLane   = ctl.wide && (!byteOnly || curQ[0]);
  assign loLane   = ctl.wide && (!byteOnly || !curQ[0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curQ   <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      if (ctl.load) begin
        curQ   <= alignedOff;
        wdataQ <= reqWdata;
        rdataQ <= '0;
      end else begin
        if (ctl.advance) begin
          curQ <= curQ + (ctl.wide ? OFF_W'(2) : OFF_W'(1));
        end
        if (ctl.capture) begin
          if (ctl.wide) begin
            if (hiLane) rdataQ[{lane[1], 1'b1, 3'b000} +: 8] <= memDataIn[15:8];
            if (loLane) rdataQ[{lane[1], 1'b0, 3'b000} +: 8] <= memDataIn[7:0];
          end else begin
            rdataQ[{lane, 3'b000} +: 8] <= memDataIn[7:0];
          end
        end
      end
    end
  end

  assign rspRdata   = rdataQ;
  assign writePulse = ctl.access && ctl.isWrite;

  always_comb begin
    memAddr    = '0;
    memA0      = 1'b0;
    memDataOut = '0;
    memDataOe  = 1'b1;
    memOeN     = 1'b1;
    memWeN     = 1'b1;
    memStrbHiN = 1'b1;
    memStrbLoN = 1'b1;
    if (ctl.span) begin
      memAddr   = curQ[OFF_W-1:1];
      memA0     = ctl.wide ? 1'b0 : curQ[0];
      memDataOe = ctl.isWrite;
      if (ctl.isWrite) begin
        memDataOut = ctl.wide ? beatHalf : {8'h00, beatByte};
      end
      memOeN = !(ctl.access && !ctl.isWrite);
      memWeN = !(writePulse && (!ctl.wide || ctl.beStyle));
      if (ctl.wide && ctl.beStyle) begin
        memStrbHiN = !hiLane;
        memStrbLoN = !loLane;
      end else if (ctl.wide) begin
        memStrbHiN = !(writePulse && hiLane);
        memStrbLoN = !(writePulse && loLane);
      end
    end
  end

endmodule

// File: rtl/asmc_top.sv
module asmc_top
  import asmc_pkg::*;
#(
  parameter int NUM_CS = 10,
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 4,
  localparam int SEL_W = $clog2(NUM_CS),
  localparam int OFF_W = ADDR_W - SEL_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic                    reqWrite,
  input  logic [1:0]              reqSize,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [31:0]             reqWdata,
  output logic                    reqAck,
  output logic [31:0]             rspRdata,
  input  logic [NUM_CS*CNT_W-1:0] cfgSetup,
  input  logic [NUM_CS*CNT_W-1:0] cfgAccess,
  input  logic [NUM_CS*CNT_W-1:0] cfgHold,
  input  logic [NUM_CS-1:0]       cfgReadyEn,
  input  logic [NUM_CS-1:0]       cfgReadyPol,
  input  logic [NUM_CS-1:0]       cfgWide,
  input  logic [NUM_CS-1:0]       cfgByteEn,
  input  logic                    readyIn,
  output logic [NUM_CS-1:0]       memCsN,
  output logic [OFF_W-2:0]        memAddr,
  output logic                    memA0,
  output logic [15:0]             memDataOut,
  output logic                    memDataOe,
  input  logic [15:0]             memDataIn,
  output logic                    memOeN,
  output logic                    memWeN,
  output logic                    memStrbHiN,
  output logic                    memStrbLoN
);

  ctlStrobes_t ctl;
  hostSize_e   sizeIn;

  assign sizeIn = hostSize_e'(reqSize);

  asmc_ctrl #(.NUM_CS(NUM_CS), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqSize    (sizeIn),
    .reqRegion  (reqAddr[ADDR_W-1 -: SEL_W]),
    .cfgSetup   (cfgSetup),
    .cfgAccess  (cfgAccess),
    .cfgHold    (cfgHold),
    .cfgReadyEn (cfgReadyEn),
    .cfgReadyPol(cfgReadyPol),
    .cfgWide    (cfgWide),
    .cfgByteEn  (cfgByteEn),
    .readyIn    (readyIn),
    .reqAck     (reqAck),
    .memCsN     (memCsN),
    .ctl        (ctl)
  );

  asmc_datapath #(.OFF_W(OFF_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .reqSize    (sizeIn),
    .reqOffset  (reqAddr[OFF_W-1:0]),
    .reqWdata   (reqWdata),
    .memDataIn  (memDataIn),
    .rspRdata   (rspRdata),
    .memAddr    (memAddr),
    .memA0      (memA0),
    .memDataOut (memDataOut),
    .memDataOe  (memDataOe),
    .memOeN     (memOeN),
    .memWeN     (memWeN),
    .memStrbHiN (memStrbHiN),
    .memStrbLoN (memStrbLoN)
  );

endmodule

// File: rtl/asmc_checker.sv
module asmc_checker #(
  parameter int NUM_CS = 10,
  parameter int AW     = 19
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqAck,
  input logic [NUM_CS-1:0] memCsN,
  input logic [AW-1:0]     memAddr,
  input logic              memA0,
  input logic [15:0]       memDataOut,
  input logic              memDataOe,
  input logic              memOeN,
  input logic              memWeN
);

  assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~memCsN));

  assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    (&memCsN) |-> (memAddr == '0 && !memA0 && memDataOut == '0 && memDataOe
                   && memOeN && memWeN));

  assert_strobe_in_span_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!memOeN || !memWeN) |-> !(&memCsN));

  assert_read_releases_R12: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> !memDataOe);

  assert_ack_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck);

  assert_ack_after_span_R11: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |-> (&memCsN));

  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!memOeN && $past(!memOeN)) |-> $stable(memAddr));

endmodule

bind asmc_top asmc_checker #(.NUM_CS(NUM_CS), .AW(OFF_W-1)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqAck     (reqAck),
  .memCsN     (memCsN),
  .memAddr    (memAddr),
  .memA0      (memA0),
  .memDataOut (memDataOut),
  .memDataOe  (memDataOe),
  .memOeN     (memOeN),
  .memWeN     (memWeN)
);

// File: tb/asmc_top_test.sv
module asmc_top_test;

  localparam int NCS = 10;
  localparam int CW  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0] reqSize = 2'b00;
  logic [23:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic reqAck;
  logic [31:0] rspRdata;
  logic [NCS*CW-1:0] cfgSetup, cfgAccess, cfgHold;
  logic [NCS-1:0] cfgReadyEn, cfgReadyPol, cfgWide, cfgByteEn;
  logic readyIn = 1'b0;
  logic [NCS-1:0] memCsN;
  logic [18:0] memAddr;
  logic memA0, memDataOe, memOeN, memWeN, memStrbHiN, memStrbLoN;
  logic [15:0] memDataOut;
  logic [15:0] memDataIn = '0;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int cS[NCS], cA[NCS], cH[NCS];
  bit cRe[NCS], cRp[NCS], cWd[NCS], cBe[NCS];

  always #5 clk = ~clk;

  asmc_top uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqAck(reqAck), .rspRdata(rspRdata), .cfgSetup(cfgSetup),
    .cfgAccess(cfgAccess), .cfgHold(cfgHold), .cfgReadyEn(cfgReadyEn),
    .cfgReadyPol(cfgReadyPol), .cfgWide(cfgWide), .cfgByteEn(cfgByteEn),
    .readyIn(readyIn), .memCsN(memCsN), .memAddr(memAddr), .memA0(memA0),
    .memDataOut(memDataOut), .memDataOe(memDataOe), .memDataIn(memDataIn),
    .memOeN(memOeN), .memWeN(memWeN), .memStrbHiN(memStrbHiN),
    .memStrbLoN(memStrbLoN)
  );

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] devByte(input int rg, input logic [19:0] a);
    return a[7:0] * 8'd7 + 8'(rg * 16) + 8'h31;
  endfunction

  // ph: 0 idle, 1 setup, 2 access, 3 hold
  task automatic checkCycle(input int ph, input int rg, input logic wr,
                            input logic [1:0] sz, input logic [19:0] cur,
                            input logic [31:0] wd, input logic ack,
                            input string accTag);
    logic [NCS-1:0] eCs;
    logic [18:0] eAddr;
    logic eA0, eOe, eOeN, eWeN, eHi, eLo, wide, be, hi, lo;
    logic [15:0] eDo;
    string sTag;
    eCs = '1;
    eAddr = '0; eA0 = 0; eDo = '0; eOe = 1; eOeN = 1; eWeN = 1; eHi = 1; eLo = 1;
    wide = 0; be = 0;
    if (ph != 0) begin
      eCs[rg] = 1'b0;
      wide = cWd[rg]; be = cBe[rg];
      hi = wide && (sz != 2'b00 || cur[0]);
      lo = wide && (sz != 2'b00 || !cur[0]);
      eAddr = cur[19:1];
      eA0   = wide ? 1'b0 : cur[0];
      eOe   = wr;
      if (wr) eDo = wide ? wd[16*cur[1] +: 16] : {8'h00, wd[8*cur[1:0] +: 8]};
      eOeN = !(ph == 2 && !wr);
      eWeN = !(ph == 2 && wr && (!wide || be));
      if (wide && be) begin
        eHi = !hi; eLo = !lo;
      end else if (wide) begin
        eHi = !(ph == 2 && wr && hi);
        eLo = !(ph == 2 && wr && lo);
      end
    end
    sTag = (ph == 0) ? "R1" : (!wide ? "R6" : (be ? "R8" : "R7"));
    check((ph == 0) ? "R1" : "R2", "chip selects", 64'(memCsN), 64'(eCs));
    check((ph == 2) ? accTag : "R3", "read strobe", 64'(memOeN), 64'(eOeN));
    check(sTag, "strobes we/hi/lo", 64'({memWeN, memStrbHiN, memStrbLoN}),
          64'({eWeN, eHi, eLo}));
    check((ph == 0) ? "R1" : "R9", "address", 64'({memAddr, memA0}), 64'({eAddr, eA0}));
    check((ph == 0) ? "R1" : "R12", "data out/oe", 64'({memDataOut, memDataOe}),
          64'({eDo, eOe}));
    check("R11", "ack", 64'(reqAck), 64'(ack));
  endtask

  task automatic runAccess(input logic wr, input logic [1:0] sz,
                           input logic [23:0] addr, input logic [31:0] wd,
                           input int rdyDelay);
    int rg;
    int beats, step;
    logic [19:0] base, cur;
    logic [31:0] expRd;
    logic act;
    bit last;
    string accTag;
    rg = int'(addr[23:20]);
    reqValid = 1; reqWrite = wr; reqSize = sz; reqAddr = addr; reqWdata = wd;
    expRd = '0;
    if (rg >= NCS) begin
      readyIn = 1'b0;
      @(negedge clk);
      checkCycle(0, 0, wr, sz, '0, wd, 1'b1, "R2");
      check("R2", "out-of-range read data", 64'(rspRdata), 64'd0);
      reqValid = 0;
      @(negedge clk);
      checkCycle(0, 0, wr, sz, '0, wd, 1'b0, "R2");
      return;
    end
    readyIn = cRp[rg];
    step = cWd[rg] ? 2 : 1;
    case (sz)
      2'b00: beats = 1;
      2'b01: beats = cWd[rg] ? 1 : 2;
      default: beats = cWd[rg] ? 2 : 4;
    endcase
    base = addr[19:0];
    if (sz == 2'b01) base[0] = 1'b0;
    else if (sz != 2'b00) base[1:0] = 2'b00;
    accTag = cRe[rg] ? "R5" : "R4";
    @(negedge clk);
    for (int b = 0; b < beats; b++) begin
      cur = base + 20'(b * step);
      for (int s = 0; s <= cS[rg]; s++) begin
        readyIn = cRp[rg];
        checkCycle(1, rg, wr, sz, cur, wd, 1'b0, accTag);
        @(negedge clk);
      end
      last = 0;
      for (int i = 0; !last; i++) begin
        act = cRe[rg] ? (i >= cA[rg] + rdyDelay) : 1'b0;
        readyIn = act ^ cRp[rg];
        memDataIn = cWd[rg] ? {devByte(rg, cur | 20'd1), devByte(rg, cur & ~20'd1)}
                            : {8'hEE, devByte(rg, cur)};
        checkCycle(2, rg, wr, sz, cur, wd, 1'b0, accTag);
        last = (i >= cA[rg]) && (!cRe[rg] || act);
        if (last && !wr) begin
          if (cWd[rg]) begin
            if (sz != 2'b00 || cur[0])
              expRd[8*{cur[1], 1'b1} +: 8] = devByte(rg, cur | 20'd1);
            if (sz != 2'b00 || !cur[0])
              expRd[8*{cur[1], 1'b0} +: 8] = devByte(rg, cur & ~20'd1);
          end else begin
            expRd[8*cur[1:0] +: 8] = devByte(rg, cur);
          end
        end
        @(negedge clk);
      end
      readyIn = cRp[rg];
      memDataIn = 16'h0;
      for (int h = 0; h <= cH[rg]; h++) begin
        checkCycle(3, rg, wr, sz, cur, wd, 1'b0, accTag);
        @(negedge clk);
      end
    end
    checkCycle(0, rg, wr, sz, '0, wd, 1'b1, "R11");
    if (!wr) check("R10", "read data", 64'(rspRdata), 64'(expRd));
    reqValid = 0;
    @(negedge clk);
    checkCycle(0, rg, wr, sz, '0, wd, 1'b0, "R11");
  endtask

  initial begin
    for (int i = 0; i < NCS; i++) begin
      cS[i] = 0; cA[i] = 0; cH[i] = 0;
      cRe[i] = 0; cRp[i] = 0; cWd[i] = 1; cBe[i] = 0;
    end
    cS[0] = 1; cA[0] = 2; cH[0] = 1;
    cS[1] = 0; cA[1] = 1; cH[1] = 0; cRe[1] = 1; cBe[1] = 1;
    cS[2] = 2; cA[2] = 0; cH[2] = 2; cRe[2] = 1; cRp[2] = 1; cWd[2] = 0;
    cWd[3] = 0;
    cS[9] = 3; cA[9] = 3; cH[9] = 3; cRp[9] = 1;
    for (int i = 0; i < NCS; i++) begin
      cfgSetup[i*CW +: CW] = CW'(cS[i]);
      cfgAccess[i*CW +: CW] = CW'(cA[i]);
      cfgHold[i*CW +: CW] = CW'(cH[i]);
      cfgReadyEn[i] = cRe[i]; cfgReadyPol[i] = cRp[i];
      cfgWide[i] = cWd[i]; cfgByteEn[i] = cBe[i];
    end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    checkCycle(0, 0, 1'b0, 2'b00, '0, '0, 1'b0, "R1");
    // R7 byte write, odd lane on 16-bit separate strobes; R4 ready ignored
    runAccess(1'b1, 2'b00, 24'h000005, 32'hAABBCCDD, 0);
    // R9 word read on 16-bit part, lower half first
    runAccess(1'b0, 2'b10, 24'h000008, 32'h0, 0);
    // R8 half write with byte enables, R5 ready late
    runAccess(1'b1, 2'b01, 24'h100006, 32'h12345678, 3);
    // R8 byte read, upper lane only, R5 ready on last counted cycle
    runAccess(1'b0, 2'b00, 24'h100003, 32'h0, 0);
    // R6 word write on 8-bit part, active-low ready
    runAccess(1'b1, 2'b10, 24'h200010, 32'hCAFEF00D, 2);
    // R9 misaligned half read on 8-bit part, low bit ignored
    runAccess(1'b0, 2'b01, 24'h200023, 32'h0, 1);
    // R3 minimum timing, 8-bit word read
    runAccess(1'b0, 2'b10, 24'h3000FC, 32'h0, 0);
    // R2 highest region, word write, size code 11
    runAccess(1'b1, 2'b11, 24'h900102, 32'h89ABCDEF, 0);
    // R2 region index beyond the last chip select
    runAccess(1'b0, 2'b10, 24'hC00010, 32'h0, 0);
    runAccess(1'b1, 2'b00, 24'hF00001, 32'h55, 0);
    // R10 byte read on 16-bit, lower lane
    runAccess(1'b0, 2'b00, 24'h000102, 32'h0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog: actual=hung expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule